// File: doc/BRIEF.md
# Chainable Serial Datagram Receiver

This block is a serial-peripheral slave that runs entirely on the system clock. It treats the serial clock, data-in and chip-select pins as ordinary asynchronous inputs. Each pin passes through a synchronizer and a short agreement filter, and edges are found by comparing filtered levels. While chip select is low, incoming bits enter a 20-bit shift register at its least significant end. The bit pushed out of the most significant end drives the serial output. Several slaves can therefore share one chip select with their data lines wired in series, and the whole string behaves as one long shift register.

When chip select falls, the shift register is preloaded from a parallel status word. Those status bits are the first bits the master reads back. When chip select rises, the block copies the register to a parallel result. Whatever the frame length, the result holds the last 20 bits that were received. A single-cycle valid strobe marks the update. Bits received earlier have already been passed on to the next slave in the chain.

Top module: `spi_chain_slave`

## Requirements
- R1: After reset, rx_data_o is 0, rx_valid_o is 0, sdo_o is 0 and sdo_oe_o is 0.
- R2: While filtered chip select is high, sdo_o is 0 and sdo_oe_o is 0. Between the filtered fall and the filtered rise of chip select, sdo_oe_o is 1.
- R3: On the falling edge of chip select, the shift register is loaded with status_i. status_i leaves on sdo_o bit 19 first, and changes to status_i after that edge do not affect the frame.
- R4: Each rising edge of the serial clock while chip select is low captures sdi_i into bit 0 of the shift register. The older contents move one place toward bit 19.
- R5: sdo_o changes only after a falling edge of the serial clock, or at the start of a frame, and then shows bit 19 of the shift register. In an N-bit frame, the bits read from sdo_o are the 20 status bits followed by the first N-20 bits received.
- R6: On the rising edge of chip select, rx_data_o takes the last 20 bits received, with the last bit in bit 0. This holds for frames of any length. A frame shorter than 20 bits leaves the low status bits in the upper positions.
- R7: rx_valid_o is high for exactly one clock per frame, in the cycle in which rx_data_o takes its new value. rx_data_o does not change in any other cycle.
- R8: With two slaves chained, a 40-bit frame delivers its first 20 bits to the downstream slave and its last 20 bits to the upstream slave.
- R9: A pulse on the serial clock or on chip select that lasts a single system clock is rejected and does not change the frame's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master |
| sdi_i | input | 1 | Serial data in |
| csn_i | input | 1 | Active-low chip select |
| status_i | input | 20 | Word loaded into the shift register when a frame starts |
| sdo_o | output | 1 | Serial data out, the bit leaving the register |
| sdo_oe_o | output | 1 | High while a frame is active |
| rx_data_o | output | 20 | Last 20 bits of the latest frame |
| rx_valid_o | output | 1 | One-cycle strobe when rx_data_o updates |

## Verification
The checker's properties assume that each serial-clock phase lasts several system clocks longer than the synchronizer and filter delay. They also assume that chip select never moves in the same filtered cycle as a serial-clock edge, and that data-in is stable before each rising clock edge. The stimulus keeps every serial-clock phase 8 system clocks long, changes data-in only at the start of a low phase, and leaves settling gaps around every chip-select edge. Deliberate violations are limited to one-clock glitches, which the filter is required to reject. Frame lengths from 1 to 64 bits and the status words are drawn from a seeded generator, and directed frames of 20, 24, 32, 40 and 8 bits are added. Two slaves are always chained, so the pass-through path is checked in every frame.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

  localparam int PIN_CNT = 3;

  // Filtered pin levels, chip select in the top bit.
  typedef struct packed {
    logic csn;
    logic sdi;
    logic sck;
  } spi_pins_t;

  // Idle level of each pin after reset: chip select high, others low.
  localparam logic [PIN_CNT-1:0] PIN_IDLE = 3'b100;

  typedef struct packed {
    logic sck_rise;
    logic sck_fall;
    logic csn_fall;
    logic csn_rise;
  } spi_evt_t;

endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/spi_in_cond.sv
module spi_in_cond #(
  parameter int   SYNC_STAGES = 2,
  parameter int   FILT_LEN    = 2,
  parameter logic IDLE_VAL    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {SYNC_STAGES{IDLE_VAL}};
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end
  end

  assign sync_bit = sync_q[SYNC_STAGES-1];

  generate
    if (FILT_LEN > 1) begin : g_filter
      logic [FILT_LEN-2:0] hist_q;
      logic [FILT_LEN-1:0] window;
      logic                agree;
      logic                level_q;
      logic                level_en;

      assign window   = {hist_q, sync_bit};
      assign agree    = (&window) | (~|window);
      assign level_en = agree && (sync_bit != level_q);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hist_q <= {(FILT_LEN-1){IDLE_VAL}};
        end else begin
          hist_q <= window[FILT_LEN-2:0];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          level_q <= IDLE_VAL;
        end else if (level_en) begin
          level_q <= sync_bit;
        end
      end

      assign level_o = level_q;
    end else begin : g_nofilter
      assign level_o = sync_bit;
    end
  endgenerate

endmodule

// File: rtl/spi_evt_det.sv
module spi_evt_det
  import spi_chain_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  spi_pins_t lvl_i,
  output spi_evt_t  evt_o
);

  spi_pins_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= spi_pins_t'(PIN_IDLE);
    end else begin
      prev_q <= lvl_i;
    end
  end

  always_comb begin
    evt_o.sck_rise =  lvl_i.sck & ~prev_q.sck;
    evt_o.sck_fall = ~lvl_i.sck &  prev_q.sck;
    evt_o.csn_fall = ~lvl_i.csn &  prev_q.csn;
    evt_o.csn_rise =  lvl_i.csn & ~prev_q.csn;
  end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_chain_pkg::*;
#(
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  spi_evt_t           evt_i,
  input  spi_pins_t          lvl_i,
  input  logic [FRAME_W-1:0] status_i,
  output logic               sdo_o,
  output logic               sdo_oe_o,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               rx_valid_o
);

  localparam int MSB = FRAME_W - 1;

  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [FRAME_W-1:0] rx_q;
  logic               sdo_q, sdo_d;
  logic               oe_q, oe_d;
  logic               vld_q, vld_d;
  logic               shreg_en, sdo_en, oe_en, rx_en;
  logic               in_frame;

  assign in_frame = ~lvl_i.csn;

  // Next-state and clock enables
  always_comb begin
    shreg_d  = shreg_q;
    sdo_d    = sdo_q;
    oe_d     = oe_q;
    vld_d    = 1'b0;
    shreg_en = 1'b0;
    sdo_en   = 1'b0;
    oe_en    = 1'b0;
    rx_en    = 1'b0;
    if (evt_i.csn_fall) begin
      shreg_d  = status_i;
      shreg_en = 1'b1;
      sdo_d    = status_i[MSB];
      sdo_en   = 1'b1;
      oe_d     = 1'b1;
      oe_en    = 1'b1;
    end else if (evt_i.csn_rise) begin
      rx_en    = 1'b1;
      vld_d    = 1'b1;
      sdo_d    = 1'b0;
      sdo_en   = 1'b1;
      oe_d     = 1'b0;
      oe_en    = 1'b1;
    end else if (in_frame) begin
      if (evt_i.sck_rise) begin
        shreg_d  = {shreg_q[MSB-1:0], lvl_i.sdi};
        shreg_en = 1'b1;
      end
      if (evt_i.sck_fall) begin
        sdo_d  = shreg_q[MSB];
        sdo_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
    end else if (shreg_en) begin
      shreg_q <= shreg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q <= 1'b0;
    end else if (sdo_en) begin
      sdo_q <= sdo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= 1'b0;
    end else if (oe_en) begin
      oe_q <= oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (rx_en) begin
      rx_q <= shreg_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign sdo_o      = sdo_q & oe_q;
  assign sdo_oe_o   = oe_q;
  assign rx_data_o  = rx_q;
  assign rx_valid_o = vld_q;

endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
  import spi_chain_pkg::*;
#(
  parameter int FRAME_W     = 20,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck_i,
  input  logic               sdi_i,
  input  logic               csn_i,
  input  logic [FRAME_W-1:0] status_i,
  output logic               sdo_o,
  output logic               sdo_oe_o,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               rx_valid_o
);

  logic               rst_n_q;
  logic [PIN_CNT-1:0] pins_raw;
  logic [PIN_CNT-1:0] pins_filt;
  spi_pins_t          lvl;
  spi_evt_t           evt;
  logic               csn_filt;

  spi_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_n_o(rst_n_q)
  );

  assign pins_raw = {csn_i, sdi_i, sck_i};

  generate
    for (genvar g = 0; g < PIN_CNT; g++) begin : g_pin
      spi_in_cond #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN),
        .IDLE_VAL   (PIN_IDLE[g])
      ) u_cond (
        .clk    (clk),
        .rst_n  (rst_n_q),
        .pin_i  (pins_raw[g]),
        .level_o(pins_filt[g])
      );
    end
  endgenerate

  assign lvl      = spi_pins_t'(pins_filt);
  assign csn_filt = lvl.csn;

  spi_evt_det u_evt (
    .clk  (clk),
    .rst_n(rst_n_q),
    .lvl_i(lvl),
    .evt_o(evt)
  );

  spi_shift_core #(.FRAME_W(FRAME_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n_q),
    .evt_i     (evt),
    .lvl_i     (lvl),
    .status_i  (status_i),
    .sdo_o     (sdo_o),
    .sdo_oe_o  (sdo_oe_o),
    .rx_data_o (rx_data_o),
    .rx_valid_o(rx_valid_o)
  );

endmodule

// File: rtl/spi_chain_slave_chk.sv
module spi_chain_slave_chk #(
  parameter int FRAME_W = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               csn_f,
  input logic               sdo_o,
  input logic               sdo_oe_o,
  input logic [FRAME_W-1:0] rx_data_o,
  input logic               rx_valid_o
);

  // R2: one cycle after a high filtered chip select the output is quiet
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csn_f |=> (!sdo_oe_o && !sdo_o));

  // R2: chip select low for two samples means the output is enabled
  p_oe_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn_f && !$past(csn_f)) |-> sdo_oe_o);

  // R6: a filtered chip-select rise is followed by the strobe
  p_valid_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csn_f) |=> rx_valid_o);

  // R7: strobe lasts one clock
  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R7: result changes only together with the strobe
  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data_o) |-> rx_valid_o);

  // R6: strobe only once chip select is back high
  p_valid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> csn_f);

endmodule

bind spi_chain_slave spi_chain_slave_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_q),
  .csn_f     (csn_filt),
  .sdo_o     (sdo_o),
  .sdo_oe_o  (sdo_oe_o),
  .rx_data_o (rx_data_o),
  .rx_valid_o(rx_valid_o)
);

// File: tb/spi_chain_slave_bench.sv
module spi_chain_slave_bench;

  localparam int W    = 20;
  localparam int HALF = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sck = 1'b0;
  logic         sdi = 1'b0;
  logic         csn = 1'b1;
  logic [W-1:0] stat_a_in = '0;
  logic [W-1:0] stat_b_in = '0;
  logic         sdo_a, oe_a, vld_a, sdo_b, oe_b, vld_b;
  logic [W-1:0] rx_a, rx_b;

  int checks = 0;
  int errors = 0;
  int cnt_a  = 0;
  int cnt_b  = 0;

  // Expected-model state
  logic [63:0]  tx;
  logic [63:0]  rd;
  int           n;
  logic [W-1:0] st_a, st_b;

  always #10 clk = ~clk;

  spi_chain_slave u_spi_chain_slave (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdi_i(sdi), .csn_i(csn),
    .status_i(stat_a_in), .sdo_o(sdo_a), .sdo_oe_o(oe_a),
    .rx_data_o(rx_a), .rx_valid_o(vld_a)
  );

  spi_chain_slave u_second (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdi_i(sdo_a), .csn_i(csn),
    .status_i(stat_b_in), .sdo_o(sdo_b), .sdo_oe_o(oe_b),
    .rx_data_o(rx_b), .rx_valid_o(vld_b)
  );

  always @(posedge clk) begin
    if (vld_a) cnt_a <= cnt_a + 1;
    if (vld_b) cnt_b <= cnt_b + 1;
  end

  function automatic logic bit_a(int i);
    if (i < W) return st_a[W-1-i];
    return tx[i-W];
  endfunction

  function automatic logic bit_b(int i);
    if (i < W) return st_b[W-1-i];
    return bit_a(i-W);
  endfunction

  function automatic logic [W-1:0] exp_rx_a();
    logic [W-1:0] r;
    for (int j = 0; j < W; j++) r[W-1-j] = bit_a(n+j);
    return r;
  endfunction

  function automatic logic [W-1:0] exp_rx_b();
    logic [W-1:0] r;
    for (int j = 0; j < W; j++) r[W-1-j] = bit_b(n+j);
    return r;
  endfunction

  function automatic logic [63:0] exp_read();
    logic [63:0] r = '0;
    for (int k = 0; k < n; k++) r[k] = bit_b(k);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // glitch: 0 none, 1 sck pulse, 2 csn pulse, 3 status change mid-frame
  task automatic run_frame(input int len, input logic [63:0] data,
                           input logic [W-1:0] sa, input logic [W-1:0] sb,
                           input int glitch, input string tag);
    logic oe_mid_a, oe_mid_b;
    n = len; tx = data; st_a = sa; st_b = sb; rd = '0;
    stat_a_in = sa; stat_b_in = sb;
    oe_mid_a = 1'b0; oe_mid_b = 1'b0;
    cnt_a = 0; cnt_b = 0;
    @(negedge clk); csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      sdi = tx[i];
      if (i == len/2 && glitch != 0) begin
        repeat (3) @(negedge clk);
        if (glitch == 1) sck = 1'b1;
        if (glitch == 2) csn = 1'b1;
        if (glitch == 3) begin stat_a_in = ~sa; stat_b_in = ~sb; end
        @(negedge clk);
        sck = 1'b0; csn = 1'b0;
        repeat (HALF-4) @(negedge clk);
        oe_mid_a = oe_a; oe_mid_b = oe_b;
      end else begin
        repeat (HALF) @(negedge clk);
        if (i == len/2) begin oe_mid_a = oe_a; oe_mid_b = oe_b; end
      end
      rd[i] = sdo_b;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (12) @(negedge clk);
    chk(oe_mid_a && oe_mid_b, {"R2 oe in frame ", tag}, {oe_mid_a, oe_mid_b}, 2'b11);
    chk(rx_a == exp_rx_a(), {"R6 R4 R3 upstream rx ", tag}, rx_a, exp_rx_a());
    chk(rx_b == exp_rx_b(), {"R8 R6 downstream rx ", tag}, rx_b, exp_rx_b());
    chk(rd == exp_read(), {"R5 R3 sdo stream ", tag}, rd, exp_read());
    chk(cnt_a == 1 && cnt_b == 1, {"R7 one strobe ", tag}, {cnt_a[15:0], cnt_b[15:0]}, 32'h0001_0001);
    chk(!sdo_a && !oe_a && !sdo_b && !oe_b, {"R2 idle output ", tag},
        {sdo_a, oe_a, sdo_b, oe_b}, 4'b0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d;
    void'($urandom(32'd5150));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk(rx_a == '0 && rx_b == '0, "R1 reset rx", {rx_a, rx_b}, 0);
    chk(!vld_a && !vld_b, "R1 reset valid", {vld_a, vld_b}, 0);
    chk(!sdo_a && !oe_a && !sdo_b && !oe_b, "R1 reset sdo", {sdo_a, oe_a, sdo_b, oe_b}, 0);

    // Directed lengths
    run_frame(20, 64'h0_000A_5C3E, 20'hF0F0F, 20'h12345, 0, "len20");
    run_frame(24, 64'h0_00C3_96A5, 20'h80001, 20'h7FFFE, 0, "len24");
    run_frame(32, 64'hDEAD_BEEF,   20'h55555, 20'hAAAAA, 0, "len32");
    run_frame(40, 64'h00_8123_4567_89, 20'h0F00F, 20'h3C3C3, 0, "R8 chain40");
    run_frame(8,  64'h0000_00B7,   20'hABCDE, 20'h13579, 0, "short8");

    // R9 glitches rejected, R3 late status change ignored
    run_frame(24, 64'h0_00F0_0F5A, 20'h24680, 20'h97531, 1, "R9 sck glitch");
    run_frame(24, 64'h0_0033_CC99, 20'h0AAAA, 20'hF5555, 2, "R9 csn glitch");
    run_frame(20, 64'h0_000F_1E2D, 20'h6B6B6, 20'h1C1C1, 3, "R3 late status");

    // Random frames
    for (int f = 0; f < 20; f++) begin
      d = {$urandom, $urandom};
      run_frame(1 + int'($urandom % 64), d, W'($urandom), W'($urandom), 0, "random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule